// File: doc/BRIEF.md
# Motif Exit Accumulation Node

This node terminates one root-to-leaf path of a motif tree. The leaf above it streams tokens of three kinds: character tokens, numeric error sums and padding. The node acts only on numeric tokens. Each such token carries the total mismatch count that one query string produced against the candidate motif. A sum no larger than the allowed error count marks that query string as a hit in a per-string record vector.

Once every query string has produced a qualifying sum, the node raises a verified flag. The flag means that the motif is a common approximate substring of the whole set. A clear input empties the record before a new search begins. The host selects the query string being streamed through an index input, and it supplies the error limit as a 4-bit value.

Top module: `cas_exit_node`

## Requirements
- R1: After reset is released, record_o is all zeros and verified_o is 0.
- R2: When tok_valid_i is 1, tok_kind_i is 1 (numeric), tok_sum_i <= err_max_i and str_idx_i < NUM_STR, bit str_idx_i of record_o is 1 from the next clock edge onward.
- R3: A numeric token whose 8-bit sum exceeds err_max_i leaves record_o unchanged. This includes sums far above the 4-bit limit, such as 255.
- R4: Tokens of kind 0 (character), kind 2 (padding) and kind 3 (reserved), and any cycle with tok_valid_i at 0, leave record_o unchanged.
- R5: A qualifying numeric token with str_idx_i >= NUM_STR leaves record_o unchanged.
- R6: A set bit stays set. Later failing sums for the same string do not clear it.
- R7: clear_i at 1 makes record_o all zeros after the next edge. It wins over a qualifying token in the same cycle.
- R8: verified_o is 1 exactly when every bit of record_o is 1.
- R9: The comparison is inclusive at both ends of the limit range. With err_max_i = 0, only a sum of 0 qualifies. With err_max_i = 15, a sum of 15 qualifies and a sum of 16 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tok_valid_i | input | 1 | A token is present this cycle |
| tok_kind_i | input | 2 | Token kind: 0 character, 1 numeric, 2 padding, 3 reserved |
| tok_sum_i | input | 8 | Token payload; the error sum when numeric |
| str_idx_i | input | $clog2(NUM_STR+1) | Index of the query string being streamed |
| err_max_i | input | 4 | Allowed error count d |
| clear_i | input | 1 | Empty the record vector |
| record_o | output | NUM_STR | Per-string hit record |
| verified_o | output | 1 | All strings recorded a hit |

## Verification
The numeric path is tried with sums below, at and above the limit, and with a sum of 255. These cases separate an inclusive comparison from a strict one, and a full 8-bit comparison from one truncated to 4 bits. Equal payloads are sent under each non-numeric kind and with valid low, which shows that the kind decode and not the value gates the write. Out-of-range indices, a failing sum after a hit, and a clear arriving together with a hit check that writes hit one slot only, that bits stick, and that clear takes priority. The vector is filled one slot at a time so that verified_o is seen low with one bit missing and high once the vector is full.

// File: rtl/cas_exit_pkg.sv
package cas_exit_pkg;
  localparam int unsigned SUM_W = 8;
  localparam int unsigned ERR_W = 4;

  typedef enum logic [1:0] {
    TK_CHAR = 2'd0,
    TK_NUM  = 2'd1,
    TK_PAD  = 2'd2,
    TK_RSV  = 2'd3
  } tok_kind_e;
endpackage

// File: rtl/cas_tok_qual.sv
module cas_tok_qual
  import cas_exit_pkg::*;
(
  input  logic             valid_i,
  input  logic [1:0]       kind_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [ERR_W-1:0] err_max_i,
  output logic             hit_o
);
  localparam int unsigned PAD_W = SUM_W - ERR_W;

  logic is_num;
  logic in_limit;

  assign is_num   = valid_i && (tok_kind_e'(kind_i) == TK_NUM);
  // full-width compare so large sums never alias into range
  assign in_limit = sum_i <= {{PAD_W{1'b0}}, err_max_i};
  assign hit_o    = is_num && in_limit;
endmodule

// File: rtl/cas_slot_dec.sv
module cas_slot_dec #(
  parameter int unsigned NUM_STR = 6,
  parameter int unsigned IDX_W   = 3
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [NUM_STR-1:0] mask_o
);
  for (genvar g = 0; g < NUM_STR; g++) begin : g_slot
    assign mask_o[g] = en_i && (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/cas_hit_rec.sv
module cas_hit_rec #(
  parameter int unsigned NUM_STR = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic [NUM_STR-1:0] set_i,
  output logic [NUM_STR-1:0] rec_o
);
  logic [NUM_STR-1:0] rec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rec_q <= '0;
    else if (clear_i) rec_q <= '0;
    else              rec_q <= rec_q | set_i;
  end

  assign rec_o = rec_q;
endmodule

// File: rtl/cas_all_set.sv
module cas_all_set #(
  parameter int unsigned NUM_STR = 6
) (
  input  logic [NUM_STR-1:0] rec_i,
  output logic               all_o
);
  assign all_o = &rec_i;
endmodule

// File: rtl/cas_exit_node.sv
module cas_exit_node
  import cas_exit_pkg::*;
#(
  parameter int unsigned NUM_STR = 6,
  localparam int unsigned IDX_W  = $clog2(NUM_STR + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tok_valid_i,
  input  logic [1:0]         tok_kind_i,
  input  logic [SUM_W-1:0]   tok_sum_i,
  input  logic [IDX_W-1:0]   str_idx_i,
  input  logic [ERR_W-1:0]   err_max_i,
  input  logic               clear_i,
  output logic [NUM_STR-1:0] record_o,
  output logic               verified_o
);
  logic               hit;
  logic [NUM_STR-1:0] set_mask;

  cas_tok_qual i_qual (
    .valid_i  (tok_valid_i),
    .kind_i   (tok_kind_i),
    .sum_i    (tok_sum_i),
    .err_max_i(err_max_i),
    .hit_o    (hit)
  );

  cas_slot_dec #(.NUM_STR(NUM_STR), .IDX_W(IDX_W)) i_dec (
    .en_i  (hit),
    .idx_i (str_idx_i),
    .mask_o(set_mask)
  );

  cas_hit_rec #(.NUM_STR(NUM_STR)) i_rec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .set_i  (set_mask),
    .rec_o  (record_o)
  );

  cas_all_set #(.NUM_STR(NUM_STR)) i_all (
    .rec_i(record_o),
    .all_o(verified_o)
  );
endmodule

// File: rtl/cas_exit_node_chk.sv
module cas_exit_node_chk
  import cas_exit_pkg::*;
#(
  parameter int unsigned NUM_STR = 6,
  parameter int unsigned IDX_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tok_valid_i,
  input logic [1:0]         tok_kind_i,
  input logic [SUM_W-1:0]   tok_sum_i,
  input logic [IDX_W-1:0]   str_idx_i,
  input logic [ERR_W-1:0]   err_max_i,
  input logic               clear_i,
  input logic [NUM_STR-1:0] record_o,
  input logic               verified_o
);
  logic is_num;
  logic below;
  logic in_rng;

  assign is_num = tok_valid_i && (tok_kind_i == 2'd1);
  assign below  = tok_sum_i <= {4'b0, err_max_i};
  assign in_rng = 32'(str_idx_i) < NUM_STR;

  assert_hit_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_num && below && in_rng && !clear_i) |=>
      (((record_o >> $past(str_idx_i)) & NUM_STR'(1)) != '0));

  assert_over_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_num && !below && !clear_i) |=> $stable(record_o));

  assert_non_num_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_num && !clear_i) |=> $stable(record_o));

  assert_bad_idx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_rng && !clear_i) |=> $stable(record_o));

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((record_o & $past(record_o)) == $past(record_o)));

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (record_o == '0));

  assert_verified_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verified_o == (record_o == {NUM_STR{1'b1}}));
endmodule

bind cas_exit_node cas_exit_node_chk #(.NUM_STR(NUM_STR), .IDX_W(IDX_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tok_valid_i(tok_valid_i),
  .tok_kind_i (tok_kind_i),
  .tok_sum_i  (tok_sum_i),
  .str_idx_i  (str_idx_i),
  .err_max_i  (err_max_i),
  .clear_i    (clear_i),
  .record_o   (record_o),
  .verified_o (verified_o)
);

// File: tb/test_cas_exit_node.sv
module test_cas_exit_node;
  localparam int N = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tok_valid_i = 1'b0;
  logic [1:0] tok_kind_i = 2'd0;
  logic [7:0] tok_sum_i = 8'd0;
  logic [2:0] str_idx_i = 3'd0;
  logic [3:0] err_max_i = 4'd0;
  logic       clear_i = 1'b0;
  logic [N-1:0] record_o;
  logic       verified_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  bit [N-1:0] model;

  always #5 clk_i = ~clk_i;

  cas_exit_node #(.NUM_STR(N)) i_cas_exit_node (
    .clk_i(clk_i), .rst_ni(rst_ni), .tok_valid_i(tok_valid_i),
    .tok_kind_i(tok_kind_i), .tok_sum_i(tok_sum_i), .str_idx_i(str_idx_i),
    .err_max_i(err_max_i), .clear_i(clear_i), .record_o(record_o),
    .verified_o(verified_o)
  );

  // behavioural reference
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) model <= '0;
    else if (clear_i) model <= '0;
    else if (tok_valid_i && tok_kind_i == 2'd1 && int'(tok_sum_i) <= int'(err_max_i)
             && int'(str_idx_i) < N)
      model[str_idx_i] <= 1'b1;
  end

  // per-cycle compare
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (record_o !== model || verified_o !== (model == {N{1'b1}})) begin
        failures++;
        $display("FAIL %s cycle compare: record=%b verified=%b expected record=%b verified=%b",
                 cur_req, record_o, verified_o, model, model == {N{1'b1}});
      end
    end
  end

  task automatic expect_out(input string req, input logic [N-1:0] rec, input logic ver);
    #1;
    checks++;
    if (record_o !== rec || verified_o !== ver) begin
      failures++;
      $display("FAIL %s: record=%b verified=%b expected record=%b verified=%b",
               req, record_o, verified_o, rec, ver);
    end
  endtask

  task automatic send(input logic v, input logic [1:0] k, input logic [7:0] s,
                      input logic [2:0] idx, input logic clr);
    tok_valid_i = v; tok_kind_i = k; tok_sum_i = s; str_idx_i = idx; clear_i = clr;
    @(negedge clk_i);
    tok_valid_i = 1'b0; clear_i = 1'b0; tok_kind_i = 2'd0; tok_sum_i = 8'd0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: expired expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cur_req = "R1"; expect_out("R1", 6'b000000, 1'b0);

    err_max_i = 4'd2;
    cur_req = "R2"; send(1, 2'd1, 8'd2, 3'd0, 0); expect_out("R2", 6'b000001, 1'b0);
    cur_req = "R3"; send(1, 2'd1, 8'd3, 3'd1, 0); expect_out("R3", 6'b000001, 1'b0);
    send(1, 2'd1, 8'd255, 3'd1, 0); expect_out("R3", 6'b000001, 1'b0);
    cur_req = "R4";
    send(1, 2'd0, 8'd0, 3'd1, 0); expect_out("R4", 6'b000001, 1'b0);
    send(1, 2'd2, 8'd0, 3'd1, 0); expect_out("R4", 6'b000001, 1'b0);
    send(1, 2'd3, 8'd0, 3'd1, 0); expect_out("R4", 6'b000001, 1'b0);
    send(0, 2'd1, 8'd0, 3'd1, 0); expect_out("R4", 6'b000001, 1'b0);
    cur_req = "R5";
    send(1, 2'd1, 8'd0, 3'd6, 0); expect_out("R5", 6'b000001, 1'b0);
    send(1, 2'd1, 8'd0, 3'd7, 0); expect_out("R5", 6'b000001, 1'b0);
    cur_req = "R6";
    send(1, 2'd1, 8'd1, 3'd1, 0); expect_out("R2", 6'b000011, 1'b0);
    send(1, 2'd1, 8'd9, 3'd0, 0); expect_out("R6", 6'b000011, 1'b0);
    cur_req = "R7"; send(1, 2'd1, 8'd0, 3'd2, 1); expect_out("R7", 6'b000000, 1'b0);

    cur_req = "R8";
    for (int i = 0; i < N - 1; i++) send(1, 2'd1, 8'd0, 3'(i), 0);
    expect_out("R8", 6'b011111, 1'b0);
    send(1, 2'd1, 8'd2, 3'd5, 0); expect_out("R8", 6'b111111, 1'b1);
    send(0, 2'd0, 8'd0, 3'd0, 1); expect_out("R7", 6'b000000, 1'b0);

    cur_req = "R9";
    err_max_i = 4'd0;
    send(1, 2'd1, 8'd1, 3'd0, 0); expect_out("R9", 6'b000000, 1'b0);
    send(1, 2'd1, 8'd0, 3'd0, 0); expect_out("R9", 6'b000001, 1'b0);
    err_max_i = 4'd15;
    send(1, 2'd1, 8'd15, 3'd1, 0); expect_out("R9", 6'b000011, 1'b0);
    send(1, 2'd1, 8'd16, 3'd2, 0); expect_out("R9", 6'b000011, 1'b0);

    @(negedge clk_i);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule